// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Bank

This block watches a bank of external lines (32 by default) and turns selected signal edges into sticky pending flags. Each line can be armed for rising edges, falling edges, both, or neither. Rising and falling captures land in two separate pending registers, so software can tell which edge occurred. Software clears flags by writing ones and can inject an event on any line through a software-trigger register.

The external lines are asynchronous and pass through a two-stage synchroniser before edge detection. A single level-high interrupt request is raised while any pending line, rising or falling, has its interrupt mask bit set. A handler can keep servicing and clearing flags until both pending registers read zero, and the request then drops. An event-mask register is stored and read back alongside the interrupt mask. It has no effect on the request.

Registers are reached through a plain word-wide port. Writes are qualified by an enable and a write strobe, and read data is combinational from the address.

Top module: `eint_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: For a line whose rising-select bit is set, a 0 to 1 change on that line sets its bit in the rising-pending register (offset 0x14). For a line whose falling-select bit is set, a 1 to 0 change sets its bit in the falling-pending register (offset 0x18). The bit reads set after at most three rising clock edges following the input change.
- R3: A line with both select bits set captures both edges. A line with neither select bit set captures no edge. The rising-select register is at 0x08 and the falling-select register is at 0x0C.
- R4: Writing a word to a pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: When a detected edge and a software clear of the same pending bit fall in the same cycle, the bit stays set. Other bits cleared by the same write still clear.
- R6: Writing 1 to bit n of the software-trigger register (offset 0x10) sets bit n of the rising-pending register. The software-trigger register always reads 0.
- R7: `irq_o` is high exactly while some bit n is set in the rising-pending or falling-pending register and bit n of the interrupt mask (offset 0x00) is 1. Without a register write, an asserted `irq_o` stays asserted.
- R8: The interrupt mask (0x00), event mask (0x04), rising select (0x08) and falling select (0x0C) read back the last value written. Any other address, for example 0x1C, reads 0 and writing it changes nothing. The event mask has no effect on `irq_o`.
- R9: Line n is controlled and reported by bit n of every register, including the top bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all state clears to 0 |
| line_i | input | LINES | Asynchronous external lines |
| bus_en | input | 1 | Register access enable |
| bus_we | input | 1 | Write strobe, used when bus_en is high |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
A lost capture leaves a pending bit clear. This shows in the pending read and in a missing `irq_o` three cycles after the line moves. A wrong clear either drops `irq_o` early or leaves it stuck high after a write of all ones. A stale synchroniser or edge-history flop misplaces captures by a cycle or misses them outright. The same-cycle race between an edge and a clear is driven on purpose, and so is a capture on the top line. Both show up on the next pending read.

// File: rtl/eint_pkg.sv
package eint_pkg;
    localparam logic [7:0] OFS_IRQ_MASK  = 8'h00;
    localparam logic [7:0] OFS_EVT_MASK  = 8'h04;
    localparam logic [7:0] OFS_RISE_SEL  = 8'h08;
    localparam logic [7:0] OFS_FALL_SEL  = 8'h0C;
    localparam logic [7:0] OFS_SW_TRIG   = 8'h10;
    localparam logic [7:0] OFS_RISE_PEND = 8'h14;
    localparam logic [7:0] OFS_FALL_PEND = 8'h18;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic [1:0] stg_d, stg_q;
        always_comb stg_d = {stg_q[0], async_i[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= stg_d;
        end
        assign sync_o[i] = stg_q[1];
    end
endmodule

// File: rtl/eint_edge.sv
module eint_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] rise_sel,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] rise_hit,
    output logic [W-1:0] fall_hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d   = sync_i;
        rise_hit = sync_i & ~prev_q & rise_sel;
        fall_hit = ~sync_i & prev_q & fall_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  rise_hit,
    input  logic [W-1:0]  fall_hit,
    output logic [W-1:0]  irq_mask,
    output logic [W-1:0]  rise_sel,
    output logic [W-1:0]  fall_sel,
    output logic [W-1:0]  rise_pend,
    output logic [W-1:0]  fall_pend
);
    typedef struct packed {
        logic [W-1:0] imask;
        logic [W-1:0] emask;
        logic [W-1:0] rsel;
        logic [W-1:0] fsel;
        logic [W-1:0] rpend;
        logic [W-1:0] fpend;
    } state_t;

    state_t       st_d, st_q;
    logic [7:0]   addr8;
    logic         wr;
    logic [W-1:0] clr_r, clr_f, sw_set;

    always_comb begin
        addr8  = 8'(bus_addr);
        wr     = bus_en & bus_we;
        clr_r  = (wr && addr8 == OFS_RISE_PEND) ? bus_wdata : '0;
        clr_f  = (wr && addr8 == OFS_FALL_PEND) ? bus_wdata : '0;
        sw_set = (wr && addr8 == OFS_SW_TRIG)   ? bus_wdata : '0;

        st_d = st_q;
        if (wr) begin
            case (addr8)
                OFS_IRQ_MASK: st_d.imask = bus_wdata;
                OFS_EVT_MASK: st_d.emask = bus_wdata;
                OFS_RISE_SEL: st_d.rsel  = bus_wdata;
                OFS_FALL_SEL: st_d.fsel  = bus_wdata;
                default:      ;
            endcase
        end
        // new captures are ORed in after the clear so an edge beats a clear
        st_d.rpend = (st_q.rpend & ~clr_r) | rise_hit | sw_set;
        st_d.fpend = (st_q.fpend & ~clr_f) | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr8)
            OFS_IRQ_MASK:  bus_rdata = st_q.imask;
            OFS_EVT_MASK:  bus_rdata = st_q.emask;
            OFS_RISE_SEL:  bus_rdata = st_q.rsel;
            OFS_FALL_SEL:  bus_rdata = st_q.fsel;
            OFS_RISE_PEND: bus_rdata = st_q.rpend;
            OFS_FALL_PEND: bus_rdata = st_q.fpend;
            default:       bus_rdata = '0;
        endcase
    end

    assign irq_mask  = st_q.imask;
    assign rise_sel  = st_q.rsel;
    assign fall_sel  = st_q.fsel;
    assign rise_pend = st_q.rpend;
    assign fall_pend = st_q.fpend;
endmodule

// File: rtl/eint_bank.sv
module eint_bank #(
    parameter int LINES = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] bus_rdata,
    output logic             irq_o
);
    logic [LINES-1:0] line_sync;
    logic [LINES-1:0] rise_sel, fall_sel;
    logic [LINES-1:0] rise_hit, fall_hit;
    logic [LINES-1:0] rise_pend, fall_pend;
    logic [LINES-1:0] irq_mask;

    eint_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    eint_edge #(.W(LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (line_sync),
        .rise_sel (rise_sel),
        .fall_sel (fall_sel),
        .rise_hit (rise_hit),
        .fall_hit (fall_hit)
    );

    eint_regs #(.W(LINES), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rise_hit  (rise_hit),
        .fall_hit  (fall_hit),
        .irq_mask  (irq_mask),
        .rise_sel  (rise_sel),
        .fall_sel  (fall_sel),
        .rise_pend (rise_pend),
        .fall_pend (fall_pend)
    );

    assign irq_o = |((rise_pend | fall_pend) & irq_mask);
endmodule

// File: rtl/eint_bank_chk.sv
module eint_bank_chk
    import eint_pkg::*;
#(
    parameter int LINES = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [LINES-1:0] bus_wdata,
    input logic [LINES-1:0] rise_hit,
    input logic [LINES-1:0] fall_hit,
    input logic [LINES-1:0] rise_pend,
    input logic [LINES-1:0] fall_pend,
    input logic             irq_o
);
    logic wr, wr_rp, wr_sw;
    assign wr    = bus_en & bus_we;
    assign wr_rp = wr && (bus_addr == OFS_RISE_PEND[AW-1:0]);
    assign wr_sw = wr && (bus_addr == OFS_SW_TRIG[AW-1:0]);

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_hit) |=> ((rise_pend & $past(rise_hit)) == $past(rise_hit))); // R5

    AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_hit) |=> ((fall_pend & $past(fall_hit)) == $past(fall_hit))); // R2

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rp |=> ((rise_pend & $past(rise_pend)) == $past(rise_pend))); // R4

    AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rp |=> ((rise_pend & $past(bus_wdata & ~rise_hit)) == '0)); // R4

    AST_SW_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sw |=> ((rise_pend & $past(bus_wdata)) == $past(bus_wdata))); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr) |=> irq_o); // R7
endmodule

bind eint_bank eint_bank_chk #(.LINES(LINES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rise_hit  (rise_hit),
    .fall_hit  (fall_hit),
    .rise_pend (rise_pend),
    .fall_pend (fall_pend),
    .irq_o     (irq_o)
);

// File: tb/sim_eint_bank.sv
`timescale 1ns/1ps
module sim_eint_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eint_bank #(.LINES(32), .AW(5)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'h00, 32'h1234_5678, 32'h1234_5678},   // R8 irq mask
        '{5'h04, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R8 event mask
        '{5'h08, 32'h0000_FFFF, 32'h0000_FFFF},   // R8 rising select
        '{5'h0C, 32'hFFFF_0000, 32'hFFFF_0000},   // R8 falling select
        '{5'h10, 32'h0000_00A5, 32'h0000_0000},   // R6 trigger reads 0
        '{5'h1C, 32'hFFFF_FFFF, 32'h0000_0000}    // R8 unmapped
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            report();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq low", {31'h0, irq_o}, 32'h0);

        // R8 / R6: vector table of write then read back
        for (int i = 0; i < 6; i++) begin
            wr(VECS[i].a, VECS[i].w);
            rd(VECS[i].a, v);
            chk("R8 readback", v, VECS[i].e);
        end
        rd(5'h14, v);
        chk("R6 trigger to rise pend", v, 32'h0000_00A5);
        rd(5'h18, v);
        chk("R6 fall pend untouched", v, 32'h0);
        chk("R7 irq with masked-in pend", {31'h0, irq_o}, 32'h1);

        // R4: write-one-to-clear
        wr(5'h14, 32'h0000_0005);
        rd(5'h14, v);
        chk("R4 partial clear", v, 32'h0000_00A0);
        wr(5'h14, 32'h0);
        rd(5'h14, v);
        chk("R4 zero write keeps", v, 32'h0000_00A0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, v);
        chk("R4 full clear", v, 32'h0);
        chk("R7 irq drops", {31'h0, irq_o}, 32'h0);

        // R2 / R3: edge selection
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h0000_0005);
        wr(5'h0C, 32'h0000_0006);
        @(negedge clk) line_i = 32'h0000_000F;
        settle();
        rd(5'h14, v);
        chk("R2 R3 rising captures", v, 32'h0000_0005);
        rd(5'h18, v);
        chk("R3 no falling capture on rise", v, 32'h0);
        chk("R7 irq masked off", {31'h0, irq_o}, 32'h0);
        @(negedge clk) line_i = 32'h0;
        settle();
        rd(5'h18, v);
        chk("R2 R3 falling captures", v, 32'h0000_0006);
        rd(5'h14, v);
        chk("R3 rise pend unchanged", v, 32'h0000_0005);
        wr(5'h00, 32'h0000_0002);
        chk("R7 irq from falling pend", {31'h0, irq_o}, 32'h1);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        chk("R7 irq after clearing both", {31'h0, irq_o}, 32'h0);

        // R9: top line
        wr(5'h08, 32'h8000_0000);
        @(negedge clk) line_i = 32'h8000_0000;
        settle();
        rd(5'h14, v);
        chk("R9 top line capture", v, 32'h8000_0000);
        wr(5'h00, 32'h8000_0000);
        chk("R9 R7 irq on top line", {31'h0, irq_o}, 32'h1);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
        chk("R8 event mask no irq", {31'h0, irq_o}, 32'h0);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14, v);
        chk("R8 unmapped write no effect", v, 32'h8000_0000);

        // R5: edge and clear in the same cycle
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0000_0011);
        wr(5'h08, 32'h0000_0001);
        @(negedge clk) line_i = 32'h8000_0001;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h14; bus_wdata = 32'h0000_0011;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd(5'h14, v);
        chk("R5 edge beats clear", v, 32'h0000_0001);

        done = 1'b1;
        report();
    end
endmodule